// File: doc/BRIEF.md
# Configurable Synchronous Serial Shift Engine

This block moves one character at a time over a four-wire-style synchronous serial link: clock, data out and data in, full duplex. The character length can be anything from 2 to 16 bits. The bit order on the wire can be most-significant-first or least-significant-first. The parallel words on both sides stay right-aligned whatever the length or order, so the engine itself picks the bit position that goes out and the position that each incoming bit lands in.

The engine is either clock master or clock slave. As master it divides the module clock by a 16-bit reload value and drives the shift clock. As slave it takes the shift clock from its input pin. In slave mode that clock passes through a two-flop synchroniser, so it must run well below half the module clock. Further controls set the idle level of the shift clock and choose whether data is launched on the leading or the trailing clock edge. Data is always sampled on the opposite edge.

A host writes a word and pulses a start strobe. A busy flag covers the transfer, and a one-cycle completion pulse marks the moment the received word is valid.

Top module: `sync_shift_engine`

## Requirements
- R1: A transfer carries exactly N bits, where N is `cfg_width` clamped to the range 2 to 16 (values 0 and 1 act as 2, values above 16 act as 16).
- R2: With `cfg_msb_first`=1 the first bit on `sdo` is `tx_data[N-1]` and later bits descend. With `cfg_msb_first`=0 the first bit is `tx_data[0]` and later bits ascend.
- R3: Received bits are right-aligned in `rx_data[N-1:0]`. The first received bit lands at position N-1 in most-significant-first order and at position 0 otherwise. `tx_data` bits above N never reach `sdo`.
- R4: While no transfer runs, `sclk_o` equals `cfg_cpol`. The leading edge of a bit is the transition away from that level. A master transfer makes exactly 2N clock transitions.
- R5: With `cfg_tx_lead`=1, `sdo` changes on leading edges and `sdi` is sampled on trailing edges. With `cfg_tx_lead`=0, the first bit is on `sdo` one cycle after the start is accepted, `sdo` changes on trailing edges, and `sdi` is sampled on leading edges.
- R6: In master mode with reload value R, each shift clock half period lasts R+1 module clocks. `rx_done` rises exactly 2N(R+1) cycles after the edge that accepts the start.
- R7: In slave mode (`cfg_master`=0) bits are shifted by transitions on `sclk_i`, and `sclk_o` stays at `cfg_cpol`.
- R8: `busy` is 1 from the cycle after an accepted start until the last clock edge of the transfer. It falls in the same cycle as a one-cycle `rx_done` pulse.
- R9: A `tx_start` pulse while `busy` is 1 is ignored: the running transfer keeps its data and its length.
- R10: While idle, `sdo` holds its last value, even when `tx_data` changes.
- R11: After reset, `busy`=0, `rx_done`=0, `sdo`=0 and `sclk_o`=`cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1: generate shift clock, 0: take it from `sclk_i` |
| cfg_width | input | 5 | Character length in bits (clamped to 2..16) |
| cfg_msb_first | input | 1 | 1: most significant bit first, 0: least significant first |
| cfg_cpol | input | 1 | Idle level of the shift clock |
| cfg_tx_lead | input | 1 | 1: launch data on leading edge, 0: on trailing edge |
| cfg_reload | input | 16 | Master divider reload; half period is reload+1 clocks |
| tx_data | input | 16 | Right-aligned word to send |
| tx_start | input | 1 | Start strobe, accepted only when idle |
| busy | output | 1 | Transfer in progress |
| rx_data | output | 16 | Right-aligned received word, valid with `rx_done` |
| rx_done | output | 1 | One-cycle pulse at the end of a transfer |
| sclk_o | output | 1 | Shift clock driven in master mode |
| sclk_i | input | 1 | Shift clock received in slave mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A wrong bit counter or a wrong position decode shows up on `sdo` at the first clock edge of a transfer. It also shows up in `rx_data` at the `rx_done` pulse, which comes too early or too late by whole half periods when the count is off. A divider that reloads wrongly stretches or shortens every half period, so the start-to-done cycle count shifts by a multiple of 2N. A stuck toggle or phase state leaves `sclk_o` away from its idle level once `busy` drops, and this is visible in the very next cycle.

// File: rtl/sync_shift_engine.sv
module sync_shift_engine #(
  parameter  int MAX_W = 16,
  parameter  int RLD_W = 16,
  localparam int IDX_W = $clog2(MAX_W + 1),
  localparam int POS_W = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic [IDX_W-1:0] cfg_width,
  input  logic             cfg_msb_first,
  input  logic             cfg_cpol,
  input  logic             cfg_tx_lead,
  input  logic [RLD_W-1:0] cfg_reload,
  input  logic [MAX_W-1:0] tx_data,
  input  logic             tx_start,
  output logic             busy,
  output logic [MAX_W-1:0] rx_data,
  output logic             rx_done,
  output logic             sclk_o,
  input  logic             sclk_i,
  output logic             sdo,
  input  logic             sdi
);

  logic             busy_q, done_q, sdo_q, tog_q;
  logic             msb_q, lead_q, master_q;
  logic [2:0]       sync_q;
  logic [RLD_W-1:0] div_q, reload_q;
  logic [POS_W:0]   edge_q;
  logic [POS_W-1:0] wm1_q;
  logic [MAX_W-1:0] tx_q, rx_q;

  logic [POS_W-1:0] wm1_in, first_pos, bit_i, cur_pos, nxt_pos;
  logic             ev, is_lead, last;

  assign wm1_in = (cfg_width < IDX_W'(2))     ? POS_W'(1) :
                  (cfg_width > IDX_W'(MAX_W)) ? POS_W'(MAX_W - 1) :
                                                POS_W'(cfg_width - IDX_W'(1));
  assign first_pos = cfg_msb_first ? wm1_in : '0;

  assign bit_i   = edge_q[POS_W:1];
  assign is_lead = ~edge_q[0];
  assign last    = (edge_q == {wm1_q, 1'b1});
  assign cur_pos = msb_q ? wm1_q - bit_i : bit_i;
  assign nxt_pos = msb_q ? wm1_q - bit_i - POS_W'(1) : bit_i + POS_W'(1);

  assign ev = busy_q & (master_q ? (div_q == '0) : (sync_q[1] ^ sync_q[2]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sclk_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                div_q <= '0;
    else if (!busy_q)          div_q <= cfg_reload;
    else if (div_q == '0)      div_q <= reload_q;
    else                       div_q <= div_q - RLD_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      sdo_q    <= 1'b0;
      tog_q    <= 1'b0;
      msb_q    <= 1'b0;
      lead_q   <= 1'b0;
      master_q <= 1'b0;
      reload_q <= '0;
      edge_q   <= '0;
      wm1_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (tx_start) begin
          busy_q   <= 1'b1;
          msb_q    <= cfg_msb_first;
          lead_q   <= cfg_tx_lead;
          master_q <= cfg_master;
          reload_q <= cfg_reload;
          wm1_q    <= wm1_in;
          tx_q     <= tx_data;
          rx_q     <= '0;
          edge_q   <= '0;
          tog_q    <= 1'b0;
          if (!cfg_tx_lead) sdo_q <= tx_data[first_pos];
        end
      end else if (ev) begin
        if (master_q) tog_q <= ~tog_q;
        edge_q <= edge_q + 1'b1;
        if (is_lead) begin
          if (lead_q) sdo_q <= tx_q[cur_pos];
          else        rx_q[cur_pos] <= sdi;
        end else begin
          if (lead_q)     rx_q[cur_pos] <= sdi;
          else if (!last) sdo_q <= tx_q[nxt_pos];
        end
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          edge_q <= '0;
          tog_q  <= 1'b0;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign rx_done = done_q;
  assign rx_data = rx_q;
  assign sdo     = sdo_q;
  assign sclk_o  = cfg_cpol ^ tog_q;

endmodule

// File: rtl/sync_shift_engine_sva.sv
module sync_shift_engine_sva #(
  parameter int RLD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_master,
  input logic             cfg_cpol,
  input logic [RLD_W-1:0] cfg_reload,
  input logic             busy,
  input logic             rx_done,
  input logic             sclk_o,
  input logic             sdo
);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);

  p_done_at_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rx_done);

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !busy);

  p_idle_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk_o == cfg_cpol));

  p_slave_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (sclk_o == cfg_cpol));

  p_sdo_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sdo));

  p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && busy && cfg_reload != '0 && sclk_o != $past(sclk_o)) |=> $stable(sclk_o));

endmodule

bind sync_shift_engine sync_shift_engine_sva #(.RLD_W(RLD_W)) u_sva (.*);

// File: tb/sync_shift_engine_bench.sv
module sync_shift_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_S = 12;
  localparam int NVEC = 9;

  // width(5) msb cpol lead reload(16) tx(16)
  localparam logic [39:0] VECS [NVEC] = '{
    {5'd8,  1'b1, 1'b0, 1'b1, 16'd2,   16'h00A5},
    {5'd8,  1'b0, 1'b0, 1'b1, 16'd1,   16'h0037},
    {5'd16, 1'b1, 1'b1, 1'b0, 16'd0,   16'hBEEF},
    {5'd2,  1'b0, 1'b1, 1'b1, 16'd3,   16'hFFFE},
    {5'd5,  1'b1, 1'b0, 1'b0, 16'd1,   16'h0013},
    {5'd12, 1'b0, 1'b1, 1'b0, 16'd2,   16'h0A5C},
    {5'd1,  1'b1, 1'b0, 1'b1, 16'd0,   16'h0001},
    {5'd20, 1'b0, 1'b0, 1'b0, 16'd1,   16'h8001},
    {5'd16, 1'b1, 1'b0, 1'b1, 16'd300, 16'h3C5A}
  };

  logic        clk = 0, rst_n = 0;
  logic        cfg_master = 1, cfg_msb_first = 0, cfg_cpol = 1, cfg_tx_lead = 1;
  logic [4:0]  cfg_width = 5'd8;
  logic [15:0] cfg_reload = 16'd1, tx_data = '0;
  logic        tx_start = 0, sclk_i = 0, sdi_drv = 0, loop_en = 1;
  logic        busy, rx_done, sclk_o, sdo, sdi;
  logic [15:0] rx_data;

  assign sdi = loop_en ? sdo : sdi_drv;

  sync_shift_engine u_sync_shift_engine (
    .clk, .rst_n, .cfg_master, .cfg_width, .cfg_msb_first, .cfg_cpol,
    .cfg_tx_lead, .cfg_reload, .tx_data, .tx_start, .busy, .rx_data,
    .rx_done, .sclk_o, .sclk_i, .sdo, .sdi
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int tog_cnt = 0, scnt = 0, done_cnt = 0;
  logic prev_sclk = 1'b1;
  logic stream [256];

  always @(negedge clk) begin
    if (rx_done) done_cnt++;
    if (sclk_o != prev_sclk) begin
      tog_cnt++;
      if ((sclk_o != cfg_cpol) != cfg_tx_lead) begin
        stream[scnt % 256] = sdo;
        scnt++;
      end
    end
    prev_sclk = sclk_o;
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff_w(input int w);
    return (w < 2) ? 2 : (w > 16) ? 16 : w;
  endfunction

  task automatic master_xfer(input int w, input logic msb, input logic cpol,
                             input logic lead, input int rld, input logic [15:0] tx,
                             input logic poke);
    int n, cnt, tog0, s0, d0;
    logic [15:0] m;
    n = eff_w(w);
    m = 16'((32'd1 << n) - 1);
    @(negedge clk);
    loop_en = 1; cfg_master = 1; cfg_width = 5'(w); cfg_msb_first = msb;
    cfg_cpol = cpol; cfg_tx_lead = lead; cfg_reload = 16'(rld);
    repeat (3) @(negedge clk);
    chk(sclk_o == cpol, "R4", "idle clock level", sclk_o, cpol);
    tog0 = tog_cnt; s0 = scnt; d0 = done_cnt;
    tx_data = tx; tx_start = 1;
    @(negedge clk);
    tx_start = 0;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    if (!lead)
      chk(sdo == (msb ? tx[n-1] : tx[0]), "R5", "first bit placed at start", sdo, msb ? tx[n-1] : tx[0]);
    cnt = 0;
    while (!rx_done && cnt < 70000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 5) begin tx_data = ~tx; tx_start = 1; end
      if (poke && cnt == 6) tx_start = 0;
    end
    chk(cnt == 2*n*(rld+1), "R6", "start to done cycles", cnt, 2*n*(rld+1));
    chk((rx_data & m) == (tx & m), poke ? "R9" : "R3", "loopback word", rx_data & m, tx & m);
    chk(busy == 1'b0, "R8", "busy low with done", busy, 0);
    @(negedge clk);
    chk(rx_done == 1'b0, "R8", "done one cycle", rx_done, 0);
    chk(sclk_o == cpol, "R4", "clock back to idle", sclk_o, cpol);
    chk(tog_cnt - tog0 == 2*n, "R4", "clock transitions", tog_cnt - tog0, 2*n);
    chk(scnt - s0 == n, "R1", "bits on wire", scnt - s0, n);
    chk(done_cnt - d0 == 1, poke ? "R9" : "R8", "done pulses", done_cnt - d0, 1);
    for (int k = 0; k < n; k++) begin
      logic e;
      e = msb ? tx[n-1-k] : tx[k];
      if (stream[(s0 + k) % 256] != e) begin
        chk(1'b0, "R2", $sformatf("wire bit %0d", k), stream[(s0 + k) % 256], e);
        break;
      end
    end
    checks++;
  endtask

  task automatic slave_xfer(input int w, input logic msb, input logic cpol,
                            input logic lead, input logic [15:0] tx, input logic [15:0] md);
    int n, d0;
    logic [15:0] m;
    logic got [16];
    n = eff_w(w);
    m = 16'((32'd1 << n) - 1);
    @(negedge clk);
    loop_en = 0; cfg_master = 0; cfg_width = 5'(w); cfg_msb_first = msb;
    cfg_cpol = cpol; cfg_tx_lead = lead; sclk_i = cpol;
    repeat (6) @(negedge clk);
    d0 = done_cnt;
    tx_data = tx; tx_start = 1;
    @(negedge clk);
    tx_start = 0;
    for (int k = 0; k < n; k++) begin
      repeat (HALF_S/2) @(negedge clk);
      sdi_drv = msb ? md[n-1-k] : md[k];
      repeat (HALF_S/2) @(negedge clk);
      if (!lead) got[k] = sdo;
      sclk_i = ~cpol;
      chk(sclk_o == cpol, "R7", "slave leaves sclk_o idle", sclk_o, cpol);
      repeat (HALF_S) @(negedge clk);
      if (lead) got[k] = sdo;
      sclk_i = cpol;
    end
    repeat (8) @(negedge clk);
    chk(done_cnt - d0 == 1, "R7", "slave done pulses", done_cnt - d0, 1);
    chk((rx_data & m) == (md & m), "R7", "slave received word", rx_data & m, md & m);
    chk(busy == 1'b0, "R8", "slave busy cleared", busy, 0);
    for (int k = 0; k < n; k++) begin
      logic e;
      e = msb ? tx[n-1-k] : tx[k];
      if (got[k] != e) begin
        chk(1'b0, "R5", $sformatf("slave wire bit %0d", k), got[k], e);
        break;
      end
    end
    checks++;
  endtask

  task automatic run_all();
    logic held;
    repeat (3) @(negedge clk);
    chk(sclk_o == 1'b1, "R11", "reset clock level", sclk_o, 1);
    chk(busy == 1'b0, "R11", "reset busy", busy, 0);
    chk(rx_done == 1'b0, "R11", "reset done", rx_done, 0);
    chk(sdo == 1'b0, "R11", "reset sdo", sdo, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      v = VECS[i];
      master_xfer(int'(v[39:35]), v[34], v[33], v[32], int'(v[31:16]), v[15:0], 1'b0);
    end

    // R9: start strobe during a transfer
    master_xfer(10, 1'b1, 1'b0, 1'b1, 2, 16'h02D3, 1'b1);

    // R10: sdo holds while idle under changing tx_data
    held = sdo;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      tx_data = 16'(k * 16'h1357);
      if (sdo != held) begin
        chk(1'b0, "R10", "idle sdo hold", sdo, held);
        break;
      end
    end
    checks++;

    // R3: bits above width ignored, even first bit MSB of short char
    master_xfer(3, 1'b1, 1'b1, 1'b0, 0, 16'hFFF2, 1'b0);

    slave_xfer(8, 1'b1, 1'b0, 1'b1, 16'h00C3, 16'h005A);
    slave_xfer(6, 1'b0, 1'b1, 1'b0, 16'hFF29, 16'h0017);
  endtask

  initial begin
    logic wd;
    wd = 0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule